// File: doc/BRIEF.md
# Memory ECC Error Status Capture

This unit sits next to a memory error-correction checker and keeps a record of what the checker finds. The checker sends single-cycle pulses for two kinds of event. A corrected event means one bit was wrong and was fixed. A double event means two bits were wrong and could not be fixed. With each pulse the checker also gives a 14-bit double-word index and a region bit. The unit keeps a sticky flag for each event kind and latches the location of the failure. It drives a maskable interrupt for corrected errors and a non-maskable request for double errors.

Software uses a single 32-bit status register. Reads show it directly. Writes use per-byte strobes, so byte, half-word and word accesses all work. Software clears the two event flags by writing 1 to them and sets the interrupt mask bit with a normal write. The location fields are read-only.

Top module: `ecc_stat_capture`

## Requirements
- R1: After the active-low reset, the status register reads 0x0000_0000, and `irq_corr_o` and `nmi_req_o` are both low.
- R2: A pulse on `dbl_evt_i` sets bit 31 at the next clock edge. `nmi_req_o` is high for exactly as long as bit 31 reads 1.
- R3: A pulse on `corr_evt_i` sets bit 30 at the next clock edge.
- R4: Bit 24 is a read/write enable. `irq_corr_o` is high exactly when bits 30 and 24 both read 1.
- R5: A write that has byte strobe 3 set and a 1 in bit 31 or bit 30 of the write data clears that flag. A 0 in that bit leaves the flag unchanged.
- R6: If an event and a write-1-to-clear of the same flag happen in the same cycle, the event wins and the flag stays set.
- R7: Bits 29:25, 23:21 and 19:14 always read 0. Writes to them, and to read-only bits 20 and 13:0, have no effect.
- R8: On a double event, bits 13:0 take the index input and bit 20 takes the region input (1 = system region, 0 = main region).
- R9: A corrected event captures index and region only if bit 31 read 0 before that edge. If bit 31 was set, the earlier capture is kept.
- R10: Byte strobe i (bit i of `reg_be_i`) enables writes to bits 8i+7:8i. A write without strobe 3 changes nothing, because every writable bit is in byte 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| corr_evt_i | input | 1 | Single-cycle pulse: corrected single-bit error |
| dbl_evt_i | input | 1 | Single-cycle pulse: uncorrectable double-bit error |
| sys_region_i | input | 1 | Region of the event, 1 = system region |
| dw_index_i | input | 14 | Double-word index of the failing location |
| reg_wr_i | input | 1 | Register write strobe |
| reg_be_i | input | 4 | Byte-lane write enables |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Status register contents |
| irq_corr_o | output | 1 | Maskable corrected-error interrupt, level |
| nmi_req_o | output | 1 | Non-maskable double-error request, level |

## Verification
The bench drives random streams that mix the two event kinds, random region and index values, and writes with random byte strobes and data. Bench functions compute the expected register image and interrupt levels each cycle. Directed cases separate the set-versus-clear priority from plain clearing. They also test a corrected event while the double flag is held, which separates the capture guard from unconditional capture. All-ones writes with and without strobe 3 separate lane gating and reserved-bit masking from ordinary writes.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned LANES    = REG_W / 8;
  localparam int unsigned IDX_W    = 14;
  localparam int unsigned DBL_BIT  = 31;
  localparam int unsigned CORR_BIT = 30;
  localparam int unsigned IE_BIT   = 24;
  localparam int unsigned SYS_BIT  = 20;
  localparam int unsigned CTL_LANE = DBL_BIT / 8;
  localparam int unsigned N_FLAGS  = 2;

  typedef enum int unsigned {FLG_DBL = 0, FLG_CORR = 1} flag_e;

  typedef struct packed {
    logic             sys;
    logic [IDX_W-1:0] idx;
  } fault_loc_t;
endpackage

// File: rtl/ecc_stat_sticky.sv
module ecc_stat_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_stat_loc.sv
module ecc_stat_loc
  import ecc_stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dbl_evt_i,
  input  logic       corr_evt_i,
  input  logic       dbl_held_i,
  input  fault_loc_t loc_i,
  output fault_loc_t loc_o
);
  logic capture;

  // double always overwrites; corrected only when no double is pending
  assign capture = dbl_evt_i | (corr_evt_i & ~dbl_held_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      loc_o <= '0;
    else if (capture) loc_o <= loc_i;
  end
endmodule

// File: rtl/ecc_stat_wrdec.sv
module ecc_stat_wrdec
  import ecc_stat_pkg::*;
(
  input  logic               wr_i,
  input  logic [LANES-1:0]   be_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [N_FLAGS-1:0] clr_o,
  output logic               ie_we_o,
  output logic               ie_d_o
);
  logic [LANES-1:0] lane_we;
  logic             unused_wr;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l] = wr_i & be_i[l];
  end

  assign clr_o[FLG_DBL]  = lane_we[CTL_LANE] & wdata_i[DBL_BIT];
  assign clr_o[FLG_CORR] = lane_we[CTL_LANE] & wdata_i[CORR_BIT];
  assign ie_we_o         = lane_we[CTL_LANE];
  assign ie_d_o          = wdata_i[IE_BIT];

  // remaining lanes and data bits hold only read-only or reserved fields
  assign unused_wr = ^{lane_we, wdata_i};
endmodule

// File: rtl/ecc_stat_capture.sv
module ecc_stat_capture
  import ecc_stat_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               corr_evt_i,
  input  logic               dbl_evt_i,
  input  logic               sys_region_i,
  input  logic [IDX_W-1:0]   dw_index_i,
  input  logic               reg_wr_i,
  input  logic [LANES-1:0]   reg_be_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_corr_o,
  output logic               nmi_req_o
);
  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic               ie_we, ie_d, ie_q;
  fault_loc_t         loc_in, loc_q;

  assign flag_set[FLG_DBL]  = dbl_evt_i;
  assign flag_set[FLG_CORR] = corr_evt_i;

  ecc_stat_wrdec u_wrdec (
    .wr_i    (reg_wr_i),
    .be_i    (reg_be_i),
    .wdata_i (reg_wdata_i),
    .clr_o   (flag_clr),
    .ie_we_o (ie_we),
    .ie_d_o  (ie_d)
  );

  ecc_stat_sticky #(.N(N_FLAGS)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .q_o    (flag_q)
  );

  assign loc_in.sys = sys_region_i;
  assign loc_in.idx = dw_index_i;

  ecc_stat_loc u_loc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dbl_evt_i  (dbl_evt_i),
    .corr_evt_i (corr_evt_i),
    .dbl_held_i (flag_q[FLG_DBL]),
    .loc_i      (loc_in),
    .loc_o      (loc_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ie_q <= 1'b0;
    else if (ie_we) ie_q <= ie_d;
  end

  always_comb begin
    reg_rdata_o              = '0;
    reg_rdata_o[DBL_BIT]     = flag_q[FLG_DBL];
    reg_rdata_o[CORR_BIT]    = flag_q[FLG_CORR];
    reg_rdata_o[IE_BIT]      = ie_q;
    reg_rdata_o[SYS_BIT]     = loc_q.sys;
    reg_rdata_o[IDX_W-1:0]   = loc_q.idx;
  end

  assign nmi_req_o  = flag_q[FLG_DBL];
  assign irq_corr_o = flag_q[FLG_CORR] & ie_q;
endmodule

// File: rtl/ecc_stat_capture_chk.sv
module ecc_stat_capture_chk
  import ecc_stat_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               corr_evt_i,
  input logic               dbl_evt_i,
  input logic               sys_region_i,
  input logic [IDX_W-1:0]   dw_index_i,
  input logic               reg_wr_i,
  input logic [LANES-1:0]   reg_be_i,
  input logic [REG_W-1:0]   reg_wdata_i,
  input logic [REG_W-1:0]   reg_rdata_o,
  input logic               irq_corr_o,
  input logic               nmi_req_o
);
  localparam logic [REG_W-1:0] RSVD_MASK = 32'h3E_EF_C0_00;
  logic ctl_wr;
  assign ctl_wr = reg_wr_i & reg_be_i[CTL_LANE];

  p_dbl_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_evt_i |=> nmi_req_o && reg_rdata_o[DBL_BIT]);
  p_corr_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_evt_i |=> reg_rdata_o[CORR_BIT]);
  p_irq_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_evt_i && reg_rdata_o[IE_BIT] && !ctl_wr) |=> irq_corr_o);
  p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && reg_wdata_i[DBL_BIT] && !dbl_evt_i) |=> !nmi_req_o);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbl_evt_i && !(ctl_wr && reg_wdata_i[DBL_BIT])) |=> $stable(nmi_req_o));
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_evt_i && ctl_wr && reg_wdata_i[CORR_BIT]) |=> reg_rdata_o[CORR_BIT]);
  p_rsvd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & RSVD_MASK) == '0);
  p_loc_dbl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_evt_i |=> (reg_rdata_o[IDX_W-1:0] == $past(dw_index_i)) &&
                  (reg_rdata_o[SYS_BIT] == $past(sys_region_i)));
  p_loc_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_evt_i && !dbl_evt_i && reg_rdata_o[DBL_BIT]) |=>
      $stable(reg_rdata_o[IDX_W-1:0]) && $stable(reg_rdata_o[SYS_BIT]));
  p_lane_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_be_i[CTL_LANE] && !corr_evt_i && !dbl_evt_i) |=>
      $stable(reg_rdata_o));
endmodule

bind ecc_stat_capture ecc_stat_capture_chk chk_i (.*);

// File: tb/ecc_stat_capture_tb_top.sv
`timescale 1ns/1ps
module ecc_stat_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        corr_evt, dbl_evt, sys_reg, wr;
  logic [13:0] idx;
  logic [3:0]  be;
  logic [31:0] wdata, rdata;
  logic        irq, nmi;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // model state
  bit m_dbl, m_corr, m_ie, m_sys;
  bit [13:0] m_idx;

  always #2.5 clk = ~clk;

  ecc_stat_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .corr_evt_i(corr_evt), .dbl_evt_i(dbl_evt),
    .sys_region_i(sys_reg), .dw_index_i(idx), .reg_wr_i(wr), .reg_be_i(be),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_corr_o(irq), .nmi_req_o(nmi)
  );

  function automatic logic [31:0] exp_reg();
    return {m_dbl, m_corr, 5'b0, m_ie, 3'b0, m_sys, 6'b0, m_idx};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit cw;
    bit old_dbl;
    cw = wr & be[3];
    old_dbl = m_dbl;
    if (dbl_evt || (corr_evt && !old_dbl)) begin
      m_sys = sys_reg;
      m_idx = idx;
    end
    m_dbl  = dbl_evt  | (m_dbl  & ~(cw & wdata[31]));
    m_corr = corr_evt | (m_corr & ~(cw & wdata[30]));
    if (cw) m_ie = wdata[24];
  endtask

  // inputs set at negedge; model advanced across posedge; compared at next negedge
  task automatic step(bit c, bit d, bit s, bit [13:0] ix, bit w, bit [3:0] b,
                      bit [31:0] wd, string tag);
    corr_evt = c; dbl_evt = d; sys_reg = s; idx = ix;
    wr = w; be = b; wdata = wd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    corr_evt = 0; dbl_evt = 0; wr = 0;
    chk({tag, " rdata"}, rdata, exp_reg());
    chk("R2 nmi", {31'b0, nmi}, {31'b0, m_dbl});
    chk("R4 irq", {31'b0, irq}, {31'b0, m_corr & m_ie});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0ecc));
    rst_n = 0; corr_evt = 0; dbl_evt = 0; sys_reg = 0; idx = '0;
    wr = 0; be = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata, 32'h0);
    chk("R1 reset irq/nmi", {30'b0, irq, nmi}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R7: all-ones write sets only the enable; reserved and read-only bits stay 0
    step(0, 0, 0, 0, 1, 4'hF, 32'h7FFF_FFFF, "R7");
    // R3/R4: corrected event with enable raises irq; main region capture
    step(1, 0, 0, 14'h1234, 0, 0, 0, "R3 R4");
    // R2/R8: double event, system region
    step(0, 1, 1, 14'h3ABC, 0, 0, 0, "R2 R8");
    // R9: corrected event while double flag held keeps location
    step(1, 0, 0, 14'h0011, 0, 0, 0, "R9");
    // R10: strobes without lane 3 change nothing
    step(0, 0, 0, 0, 1, 4'h7, 32'hFFFF_FFFF, "R10");
    // R5: writing 0 to flags leaves them, keeps enable
    step(0, 0, 0, 0, 1, 4'h8, 32'h0100_0000, "R5 zero");
    // R6: corrected event and its clear in same cycle
    step(1, 0, 1, 14'h0F0F, 1, 4'h8, 32'h4100_0000, "R6");
    // R5: clear both flags
    step(0, 0, 0, 0, 1, 4'h8, 32'hC100_0000, "R5 clear");
    // R9: with double clear, corrected event captures again
    step(1, 0, 1, 14'h2222, 0, 0, 0, "R9 capture");
    // R6: double event and clear in same cycle
    step(0, 1, 0, 14'h0001, 1, 4'hF, 32'h8000_0000, "R6 dbl");
    // R4: enable off masks irq
    step(0, 0, 0, 0, 1, 4'h8, 32'h0000_0000, "R4 mask");

    for (int i = 0; i < 800; i++) begin
      step(($urandom % 6) == 0, ($urandom % 10) == 0, 1'($urandom),
           14'($urandom), ($urandom % 3) == 0, 4'($urandom), $urandom,
           "R8 R9 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule